// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that software must keep feeding. A 12-bit down-counter advances once per prescaled tick. If software lets it run out, the block raises a one-clock reset request. The prescaler divides the clock by a power of two between 4 and 256, chosen by a 3-bit code.

Software reaches the block through a small write port with four register slots: key, prescaler, reload and status. All control goes through 16-bit magic values written to the key slot:
- one value starts the watchdog;
- one value refreshes the counter;
- two values open or close write access to the prescaler and reload slots.

Once started, the watchdog cannot be stopped by any write. Only a system reset stops it. Two status bits show that a recent prescaler or reload update is still settling. Each bit clears by itself after a fixed number of prescaled ticks.

The current prescaler code, reload value, count, running state and status are brought out as plain outputs so that surrounding logic can read them.

Top module: `wdg_top`

## Requirements
- R1: After reset the watchdog is stopped, the count and reload value are 0xFFF, the prescaler code is 0, both status bits are 0 and no reset request is raised.
- R2: A write of 0xCCCC to the key slot (select 0) sets the running state and loads the count from the reload value on the next clock.
- R3: A write of 0xAAAA to the key slot loads the count from the reload value and closes write access to the prescaler and reload slots. A refresh that comes sooner than the timeout prevents any reset request. A key load takes priority over a tick in the same cycle.
- R4: A write of 0x5555 to the key slot opens write access to the prescaler slot (select 1, data bits 2:0) and the reload slot (select 2, data bits 11:0). A write of 0x0000 closes it.
- R5: While write access is closed, writes to the prescaler or reload slots leave the stored values unchanged.
- R6: A key write with any value other than the four defined ones changes nothing.
- R7: A free-running divider produces one tick every 4 << code clocks. Code 7 divides by 256, the same as code 6. While running, each tick lowers the count by one.
- R8: On a tick that finds the count at zero while running, the reset request is high for exactly one clock and the count reloads from the reload value. No request is raised while stopped.
- R9: No key value stops a running watchdog.
- R10: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each bit stays set for UPD_TICKS prescaled ticks and then clears by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Slot select: 0 key, 1 prescaler, 2 reload, 3 status (read-only) |
| wr_data | input | 16 | Write data |
| running_o | output | 1 | Watchdog has been started |
| count_o | output | 12 | Current down-counter value |
| prescale_o | output | 3 | Stored prescaler code |
| reload_o | output | 12 | Stored reload value |
| status_o | output | 2 | Bit 0 prescaler update busy, bit 1 reload update busy |
| rst_req_o | output | 1 | One-clock reset request on timeout |

## Verification
The bench keeps the default 12-bit counter and the 4-to-256 prescaler range, and shortens UPD_TICKS to 3. This lets both status bits rise and clear within a few dozen clocks. Small reload values such as 5 bring a real timeout, with its one-clock pulse and reload, into a short run. Intervals between count changes are measured directly for code 1 (8 clocks) and code 7 (256 clocks).

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN   = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_CLOSE  = 16'h0000;

    localparam logic [1:0] SEL_KEY = 2'd0;
    localparam logic [1:0] SEL_PSC = 2'd1;
    localparam logic [1:0] SEL_RLD = 2'd2;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_START,
        CMD_FEED,
        CMD_OPEN,
        CMD_CLOSE
    } wdg_cmd_e;
endpackage

// File: rtl/wdg_key_decode.sv
module wdg_key_decode
    import wdg_pkg::*;
(
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    output wdg_cmd_e         cmd_o
);
    always_comb begin
        cmd_o = CMD_NONE;
        if (wr_en && wr_sel == SEL_KEY) begin
            unique case (wr_data)
                KEY_START: cmd_o = CMD_START;
                KEY_FEED:  cmd_o = CMD_FEED;
                KEY_OPEN:  cmd_o = CMD_OPEN;
                KEY_CLOSE: cmd_o = CMD_CLOSE;
                default:   cmd_o = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PSC_W     = 3,
    parameter int BASE_LOG2 = 2,
    parameter int MAX_CODE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] code_i,
    output logic             tick_o
);
    localparam int DIV_W = BASE_LOG2 + MAX_CODE;

    logic [DIV_W-1:0] div_d, div_q;
    logic [PSC_W-1:0] eff_code;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    always_comb begin
        eff_code = (code_i > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : code_i;
        span     = (DIV_W+1)'(1) << (BASE_LOG2 + int'(eff_code));
        mask     = DIV_W'(span - (DIV_W+1)'(1));
        tick_o   = ((div_q & mask) == mask);
        div_d    = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R7: the smallest division is 4, so ticks never come back to back
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdg_upd_flag.sv
module wdg_upd_flag #(
    parameter int UPD_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic tick_i,
    output logic busy_o
);
    localparam int CW = $clog2(UPD_TICKS + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (set_i)                      left_d = CW'(UPD_TICKS);
        else if (tick_i && left_q != 0) left_d = left_q - CW'(1);
        busy_o = (left_q != 0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    a_r10_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> busy_o);
    a_r10_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick_i));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PSC_W     = 3,
    parameter int UPD_TICKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic [PSC_W-1:0] prescale_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [1:0]       status_o,
    output logic             rst_req_o
);
    localparam int NFLAG = 2;

    typedef struct packed {
        logic             run;
        logic             open;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } wdg_state_t;

    wdg_state_t st_d, st_q;
    wdg_cmd_e   cmd;
    logic       tick;
    logic       load;
    logic [NFLAG-1:0] upd_set;
    logic [NFLAG-1:0] upd_busy;

    wdg_key_decode u_key (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmd_o   (cmd)
    );

    wdg_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (st_q.psc),
        .tick_o (tick)
    );

    assign upd_set[0] = wr_en && st_q.open && (wr_sel == SEL_PSC);
    assign upd_set[1] = wr_en && st_q.open && (wr_sel == SEL_RLD);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        wdg_upd_flag #(.UPD_TICKS(UPD_TICKS)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (upd_set[g]),
            .tick_i (tick),
            .busy_o (upd_busy[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        load     = (cmd == CMD_START) || (cmd == CMD_FEED);

        case (cmd)
            CMD_START: st_d.run  = 1'b1;
            CMD_FEED:  st_d.open = 1'b0;
            CMD_OPEN:  st_d.open = 1'b1;
            CMD_CLOSE: st_d.open = 1'b0;
            default: ;
        endcase

        if (load) begin
            st_d.cnt = st_q.rld;
        end else if (st_q.run && tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.rld;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (upd_set[0]) st_d.psc = wr_data[PSC_W-1:0];
        if (upd_set[1]) st_d.rld = wr_data[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run  <= 1'b0;
            st_q.open <= 1'b0;
            st_q.psc  <= '0;
            st_q.rld  <= '1;
            st_q.cnt  <= '1;
            st_q.req  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o  = st_q.run;
    assign count_o    = st_q.cnt;
    assign prescale_o = st_q.psc;
    assign reload_o   = st_q.rld;
    assign status_o   = upd_busy;
    assign rst_req_o  = st_q.req;

    a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> running_o);
    a_r8_req_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    a_r8_no_req_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |=> !rst_req_o);
    a_r5_psc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PSC && !st_q.open) |=> $stable(prescale_o));
    a_r5_rld_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RLD && !st_q.open) |=> $stable(reload_o));
    a_r3_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FEED) |=> (count_o == $past(reload_o)) && !rst_req_o);
endmodule

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
    localparam int UPD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        running_o;
    logic [11:0] count_o;
    logic [2:0]  prescale_o;
    logic [11:0] reload_o;
    logic [1:0]  status_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdg_top #(.UPD_TICKS(UPD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .running_o(running_o), .count_o(count_o),
        .prescale_o(prescale_o), .reload_o(reload_o), .status_o(status_o),
        .rst_req_o(rst_req_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_run, m_open, m_psc, m_rld, m_cnt, m_req, m_div;
    int m_flag[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_open = 0; m_psc = 0; m_rld = 4095; m_cnt = 4095;
            m_req = 0; m_div = 0; m_flag[0] = 0; m_flag[1] = 0;
        end else begin
            int mask, tick, ld, n_run, n_open, n_psc, n_rld, n_cnt, n_req;
            bit key, wp, wr;
            mask = (m_psc > 6) ? 255 : ((4 << m_psc) - 1);
            tick = ((m_div & mask) == mask);
            key = wr_en && wr_sel == 0;
            ld = key && (wr_data == 16'hCCCC || wr_data == 16'hAAAA);
            n_run = m_run; n_open = m_open; n_psc = m_psc; n_rld = m_rld;
            n_cnt = m_cnt; n_req = 0;
            if (key && wr_data == 16'hCCCC) n_run = 1;
            if (key && (wr_data == 16'hAAAA || wr_data == 16'h0000)) n_open = 0;
            if (key && wr_data == 16'h5555) n_open = 1;
            if (ld) n_cnt = m_rld;
            else if (m_run != 0 && tick != 0) begin
                if (m_cnt == 0) begin n_cnt = m_rld; n_req = 1; end
                else n_cnt = m_cnt - 1;
            end
            wp = wr_en && m_open != 0 && wr_sel == 1;
            wr = wr_en && m_open != 0 && wr_sel == 2;
            if (wp) n_psc = int'(wr_data[2:0]);
            if (wr) n_rld = int'(wr_data[11:0]);
            for (int i = 0; i < 2; i++) begin
                if ((i == 0) ? wp : wr) m_flag[i] = UPD;
                else if (tick != 0 && m_flag[i] > 0) m_flag[i] = m_flag[i] - 1;
            end
            m_run = n_run; m_open = n_open; m_psc = n_psc; m_rld = n_rld;
            m_cnt = n_cnt; m_req = n_req; m_div = (m_div + 1) % 256;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model running", int'(running_o), m_run);
            chk("R7 model count", int'(count_o), m_cnt);
            chk("R5 model prescale", int'(prescale_o), m_psc);
            chk("R5 model reload", int'(reload_o), m_rld);
            chk("R10 model status", int'(status_o),
                (m_flag[1] > 0 ? 2 : 0) + (m_flag[0] > 0 ? 1 : 0));
            chk("R8 model request", int'(rst_req_o), m_req);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'd0; wr_sel = 2'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_interval(output int gap);
        int v;
        int t;
        gap = -1;
        v = int'(count_o);
        t = 0;
        while (int'(count_o) == v && t < 600) begin @(negedge clk); t++; end
        v = int'(count_o);
        t = 0;
        while (int'(count_o) == v && t < 600) begin @(negedge clk); t++; end
        gap = t;
    endtask

    initial begin
        int seen;
        int gap;
        idle(3);
        // R1 reset state
        chk("R1 running", int'(running_o), 0);
        chk("R1 count", int'(count_o), 4095);
        chk("R1 reload", int'(reload_o), 4095);
        chk("R1 prescale", int'(prescale_o), 0);
        chk("R1 status", int'(status_o), 0);
        chk("R1 request", int'(rst_req_o), 0);
        rst_n = 1'b1;
        idle(2);

        // R5 closed by default
        wr(2'd2, 16'd77);
        chk("R5 locked reload", int'(reload_o), 4095);

        // R4 open, R10 flags
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        chk("R10 psc busy bit0", int'(status_o), 1);
        wr(2'd2, 16'd5);
        chk("R4 reload written", int'(reload_o), 5);
        chk("R10 rld busy bit1", int'(status_o[1]), 1);
        idle(7);
        chk("R10 still busy", int'(status_o[1]), 1);
        idle(4);
        chk("R10 self clear", int'(status_o), 0);

        // R4 close with 0x0000, R6 unknown key
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd9);
        chk("R4 close blocks", int'(reload_o), 5);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd9);
        chk("R6 unknown key no unlock", int'(reload_o), 5);
        chk("R6 unknown key no start", int'(running_o), 0);
        chk("R6 count untouched", int'(count_o), 4095);

        // R2 start
        wr(2'd0, 16'hCCCC);
        chk("R2 running", int'(running_o), 1);
        chk("R2 count loaded", int'(count_o), 5);

        // R8 timeout pulse
        seen = 0;
        for (int i = 0; i < 200 && seen == 0; i++) begin
            @(negedge clk);
            if (rst_req_o) seen = 1;
        end
        chk("R8 request seen", seen, 1);
        chk("R8 count reloaded", int'(count_o), 5);
        @(negedge clk);
        chk("R8 one clock", int'(rst_req_o), 0);

        // R3 refresh keeps request away, and locks
        wr(2'd0, 16'h5555);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            wr(2'd0, 16'hAAAA);
            chk("R3 refresh loads", int'(count_o), 5);
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (rst_req_o) seen = 1;
            end
        end
        chk("R3 no request while fed", seen, 0);
        wr(2'd2, 16'd9);
        chk("R3 refresh locks", int'(reload_o), 5);

        // R9 no key stops it
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        chk("R9 still running", int'(running_o), 1);
        seen = 0;
        for (int i = 0; i < 200 && seen == 0; i++) begin
            @(negedge clk);
            if (rst_req_o) seen = 1;
        end
        chk("R9 still times out", seen, 1);

        // R7 tick intervals
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd100);
        wr(2'd1, 16'd7);
        wr(2'd0, 16'hAAAA);
        chk("R7 code 7 stored", int'(prescale_o), 7);
        tick_interval(gap);
        chk("R7 code 7 divides by 256", gap, 256);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        wr(2'd0, 16'hAAAA);
        tick_interval(gap);
        chk("R7 code 1 divides by 8", gap, 8);
        wr(2'd1, 16'd3);
        chk("R5 locked prescale", int'(prescale_o), 1);

        idle(20);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule